// File: doc/BRIEF.md
# Key Slot Access Controller

This block holds the security controls of a block-cipher engine with several key slots. Software reaches it through a 32-bit register port with word addressing. It keeps an engine-disable flag, a 2-bit active key index, a key-schedule-disable flag, and a read-enable and an update-enable bit for each key slot. There are four general slots and one dedicated slot, index 4.

The engine-disable flag and every per-slot enable work as one-way locks. Software can move them toward the locked state. Only reset moves them back.

The block also sits between the key storage and the cipher datapath. Key or IV words read from a slot without read permission come out as zero. A key write aimed at a slot without update permission is dropped without any error.

Top module: `key_slot_guard`

## Requirements
- R1: After reset, every slot read enable and update enable is 1, and engine disable, key index and key-schedule disable are all 0. Every mapped register reads back these values.
- R2: Writing 1 to bit 0 of word 0 sets engine disable. Any later write to word 0, including all zeros, leaves it set. Word 0 then reads exactly 0x00000001, and `engine_dis_o` stays high.
- R3: The slot register for slot i sits at word 4+i, for i = 0 to 4. Bit 0 is the read enable and bit 1 is the update enable. Writing 0 to a bit clears it. Writing 1 to a cleared bit has no effect until reset.
- R4: `key_rd_data_o` equals `key_rd_data_i` in the same cycle when `key_rd_slot_i` names a slot whose read enable is 1. Otherwise `key_rd_data_o` is all zeros.
- R5: `key_wr_req_o` is high in the same cycle only when `key_wr_req_i` is high and `key_wr_slot_i` names a slot whose update enable is 1.
- R6: Bits 1:0 of word 1 hold the key index. The key index can be rewritten freely, drives `key_idx_o`, and reads back with the upper bits as zero.
- R7: Bit 0 of word 2 is key-schedule disable. It can be rewritten freely and drives `key_sched_dis_o`.
- R8: A read request returns its data on `reg_rdata_o` one cycle later. In a cycle after no read request, `reg_rdata_o` is zero. Words 3 and 9 to 15 read as zero, and writes to them change nothing.
- R9: Slot numbers 5 to 7 on the key ports are always denied, for both reads and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_req_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 4 | Word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, one cycle after the request |
| key_rd_slot_i | input | 3 | Slot number of the key/IV read |
| key_rd_data_i | input | 32 | Word from key storage |
| key_rd_data_o | output | 32 | Gated word toward the datapath |
| key_wr_req_i | input | 1 | Key write request from the datapath |
| key_wr_slot_i | input | 3 | Slot number of the key write |
| key_wr_req_o | output | 1 | Gated key write request toward storage |
| engine_dis_o | output | 1 | Engine disabled |
| key_idx_o | output | 2 | Active key slot index |
| key_sched_dis_o | output | 1 | Key schedule generation disabled |

## Verification
Register read data is due one clock after the request. The bench raises the request at a falling edge and samples `reg_rdata_o` at the next falling edge. A register write takes effect at the rising edge between those two points, so every control output and every gate is checked from the following falling edge onward.

The key read and write gates are combinational. The bench sets the slot and the data at a falling edge and checks 1 ns later, with no clock edge in between. After each register write, the bench reads back the complete address map and sweeps all eight slot numbers through both key gates.

// File: rtl/key_slot_guard_pkg.sv
package key_slot_guard_pkg;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned ADDR_W    = 4;
  localparam int unsigned IDX_W     = 2;
  localparam int unsigned GEN_SLOTS = 1 << IDX_W;
  localparam int unsigned NUM_SLOTS = GEN_SLOTS + 1;  // + dedicated slot
  localparam int unsigned SLOT_W    = $clog2(NUM_SLOTS);
  localparam int unsigned ADR_SEC   = 0;
  localparam int unsigned ADR_CFG   = 1;
  localparam int unsigned ADR_EXT   = 2;
  localparam int unsigned ADR_SLOT0 = 4;
  localparam int unsigned BIT_RD    = 0;
  localparam int unsigned BIT_UP    = 1;
endpackage

// File: rtl/ksg_slot_lock.sv
module ksg_slot_lock (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic rd_bit_i,
  input  logic up_bit_i,
  output logic rd_en_o,
  output logic up_en_o
);
  // enables can only fall; reset is the sole way back up
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_en_o <= 1'b1;
      up_en_o <= 1'b1;
    end else if (wr_i) begin
      rd_en_o <= rd_en_o & rd_bit_i;
      up_en_o <= up_en_o & up_bit_i;
    end
  end
endmodule

// File: rtl/ksg_cfg_regs.sv
module ksg_cfg_regs #(
  parameter int unsigned IDX_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_sec_i,
  input  logic             wr_cfg_i,
  input  logic             wr_ext_i,
  input  logic [IDX_W-1:0] wdata_i,
  output logic             eng_dis_o,
  output logic [IDX_W-1:0] key_idx_o,
  output logic             sched_dis_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eng_dis_o   <= 1'b0;
      key_idx_o   <= '0;
      sched_dis_o <= 1'b0;
    end else begin
      if (wr_sec_i) eng_dis_o   <= eng_dis_o | wdata_i[0];
      if (wr_cfg_i) key_idx_o   <= wdata_i;
      if (wr_ext_i) sched_dis_o <= wdata_i[0];
    end
  end
endmodule

// File: rtl/ksg_access_gate.sv
module ksg_access_gate #(
  parameter int unsigned NUM_SLOTS = 5,
  parameter int unsigned SLOT_W    = 3,
  parameter int unsigned DATA_W    = 32
) (
  input  logic [NUM_SLOTS-1:0] rd_en_i,
  input  logic [NUM_SLOTS-1:0] up_en_i,
  input  logic [SLOT_W-1:0]    rd_slot_i,
  input  logic [DATA_W-1:0]    rd_data_i,
  output logic [DATA_W-1:0]    rd_data_o,
  input  logic                 wr_req_i,
  input  logic [SLOT_W-1:0]    wr_slot_i,
  output logic                 wr_req_o
);
  localparam int unsigned PAD = 1 << SLOT_W;
  // unpopulated slot numbers see a zero enable
  logic [PAD-1:0] rd_pad, up_pad;
  assign rd_pad = PAD'(rd_en_i);
  assign up_pad = PAD'(up_en_i);

  assign rd_data_o = rd_pad[rd_slot_i] ? rd_data_i : '0;
  assign wr_req_o  = wr_req_i & up_pad[wr_slot_i];
endmodule

// File: rtl/key_slot_guard.sv
module key_slot_guard
  import key_slot_guard_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_req_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [SLOT_W-1:0] key_rd_slot_i,
  input  logic [DATA_W-1:0] key_rd_data_i,
  output logic [DATA_W-1:0] key_rd_data_o,
  input  logic              key_wr_req_i,
  input  logic [SLOT_W-1:0] key_wr_slot_i,
  output logic              key_wr_req_o,
  output logic              engine_dis_o,
  output logic [IDX_W-1:0]  key_idx_o,
  output logic              key_sched_dis_o
);
  logic                 wr_stb;
  logic [NUM_SLOTS-1:0] slot_rd_en, slot_up_en;
  logic [DATA_W-1:0]    rd_mux;
  logic                 unused_wdata;

  assign wr_stb       = reg_req_i & reg_we_i;
  assign unused_wdata = ^reg_wdata_i[DATA_W-1:IDX_W];

  ksg_cfg_regs #(.IDX_W(IDX_W)) u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_sec_i    (wr_stb && reg_addr_i == ADDR_W'(ADR_SEC)),
    .wr_cfg_i    (wr_stb && reg_addr_i == ADDR_W'(ADR_CFG)),
    .wr_ext_i    (wr_stb && reg_addr_i == ADDR_W'(ADR_EXT)),
    .wdata_i     (reg_wdata_i[IDX_W-1:0]),
    .eng_dis_o   (engine_dis_o),
    .key_idx_o   (key_idx_o),
    .sched_dis_o (key_sched_dis_o)
  );

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    ksg_slot_lock u_lock (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_i     (wr_stb && reg_addr_i == ADDR_W'(ADR_SLOT0 + i)),
      .rd_bit_i (reg_wdata_i[BIT_RD]),
      .up_bit_i (reg_wdata_i[BIT_UP]),
      .rd_en_o  (slot_rd_en[i]),
      .up_en_o  (slot_up_en[i])
    );
  end

  ksg_access_gate #(
    .NUM_SLOTS (NUM_SLOTS),
    .SLOT_W    (SLOT_W),
    .DATA_W    (DATA_W)
  ) u_gate (
    .rd_en_i   (slot_rd_en),
    .up_en_i   (slot_up_en),
    .rd_slot_i (key_rd_slot_i),
    .rd_data_i (key_rd_data_i),
    .rd_data_o (key_rd_data_o),
    .wr_req_i  (key_wr_req_i),
    .wr_slot_i (key_wr_slot_i),
    .wr_req_o  (key_wr_req_o)
  );

  always_comb begin
    rd_mux = '0;
    if (reg_addr_i == ADDR_W'(ADR_SEC)) rd_mux[0] = engine_dis_o;
    if (reg_addr_i == ADDR_W'(ADR_CFG)) rd_mux[IDX_W-1:0] = key_idx_o;
    if (reg_addr_i == ADDR_W'(ADR_EXT)) rd_mux[0] = key_sched_dis_o;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (reg_addr_i == ADDR_W'(ADR_SLOT0 + i)) begin
        rd_mux[BIT_RD] = slot_rd_en[i];
        rd_mux[BIT_UP] = slot_up_en[i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) reg_rdata_o <= '0;
    else         reg_rdata_o <= (reg_req_i && !reg_we_i) ? rd_mux : '0;
  end
endmodule

// File: rtl/key_slot_guard_chk.sv
module key_slot_guard_chk
  import key_slot_guard_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 reg_req_i,
  input logic                 reg_we_i,
  input logic [ADDR_W-1:0]    reg_addr_i,
  input logic [DATA_W-1:0]    reg_wdata_i,
  input logic [DATA_W-1:0]    reg_rdata_o,
  input logic [SLOT_W-1:0]    key_rd_slot_i,
  input logic [DATA_W-1:0]    key_rd_data_o,
  input logic                 key_wr_req_i,
  input logic [SLOT_W-1:0]    key_wr_slot_i,
  input logic                 key_wr_req_o,
  input logic                 engine_dis_o,
  input logic [IDX_W-1:0]     key_idx_o,
  input logic                 key_sched_dis_o,
  input logic [NUM_SLOTS-1:0] slot_rd_en,
  input logic [NUM_SLOTS-1:0] slot_up_en
);
  localparam int unsigned PAD = 1 << SLOT_W;
  logic [PAD-1:0] rd_pad, up_pad;
  assign rd_pad = PAD'(slot_rd_en);
  assign up_pad = PAD'(slot_up_en);

  AST_ENG_DIS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    engine_dis_o |=> engine_dis_o); // R2
  AST_RD_EN_ONE_WAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((~$past(slot_rd_en)) & slot_rd_en) == '0); // R3
  AST_UP_EN_ONE_WAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((~$past(slot_up_en)) & slot_up_en) == '0); // R3
  AST_RD_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_rd_data_o != '0 |-> rd_pad[key_rd_slot_i]); // R4
  AST_WR_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_wr_req_o |-> key_wr_req_i && up_pad[key_wr_slot_i]); // R5
  AST_WR_NO_HIGH_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_wr_slot_i >= SLOT_W'(NUM_SLOTS) |-> !key_wr_req_o); // R9
  AST_IDX_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_i && reg_we_i && reg_addr_i == ADDR_W'(ADR_CFG)
    |=> key_idx_o == $past(reg_wdata_i[IDX_W-1:0])); // R6
  AST_SCHED_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_i && reg_we_i && reg_addr_i == ADDR_W'(ADR_EXT)
    |=> key_sched_dis_o == $past(reg_wdata_i[0])); // R7
  AST_IDLE_RDATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_req_i && !reg_we_i) |=> reg_rdata_o == '0); // R8
  AST_HOLE_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_i && !reg_we_i && reg_addr_i == ADDR_W'(3) |=> reg_rdata_o == '0); // R8
endmodule

bind key_slot_guard key_slot_guard_chk u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .reg_req_i       (reg_req_i),
  .reg_we_i        (reg_we_i),
  .reg_addr_i      (reg_addr_i),
  .reg_wdata_i     (reg_wdata_i),
  .reg_rdata_o     (reg_rdata_o),
  .key_rd_slot_i   (key_rd_slot_i),
  .key_rd_data_o   (key_rd_data_o),
  .key_wr_req_i    (key_wr_req_i),
  .key_wr_slot_i   (key_wr_slot_i),
  .key_wr_req_o    (key_wr_req_o),
  .engine_dis_o    (engine_dis_o),
  .key_idx_o       (key_idx_o),
  .key_sched_dis_o (key_sched_dis_o),
  .slot_rd_en      (slot_rd_en),
  .slot_up_en      (slot_up_en)
);

// File: tb/key_slot_guard_test.sv
`timescale 1ns/1ps
module key_slot_guard_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_req_i = 1'b0, reg_we_i = 1'b0;
  logic [3:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic [2:0]  key_rd_slot_i = '0, key_wr_slot_i = '0;
  logic [31:0] key_rd_data_i = '0, key_rd_data_o;
  logic        key_wr_req_i = 1'b0, key_wr_req_o;
  logic        engine_dis_o, key_sched_dis_o;
  logic [1:0]  key_idx_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference state
  bit       m_rd [5];
  bit       m_up [5];
  bit       m_dis, m_sched;
  bit [1:0] m_idx;

  always #4 clk_i = ~clk_i;

  key_slot_guard uut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_reg(int a);
    if (a == 0) return {31'b0, m_dis};
    if (a == 1) return {30'b0, m_idx};
    if (a == 2) return {31'b0, m_sched};
    if (a >= 4 && a <= 8) return {30'b0, m_up[a-4], m_rd[a-4]};
    return '0;
  endfunction

  task automatic reg_write(int a, logic [31:0] d);
    reg_req_i = 1; reg_we_i = 1; reg_addr_i = 4'(a); reg_wdata_i = d;
    @(negedge clk_i);
    reg_req_i = 0; reg_we_i = 0;
    if (a == 0) m_dis = m_dis | d[0];
    if (a == 1) m_idx = d[1:0];
    if (a == 2) m_sched = d[0];
    if (a >= 4 && a <= 8) begin
      m_rd[a-4] = m_rd[a-4] & d[0];
      m_up[a-4] = m_up[a-4] & d[1];
    end
  endtask

  task automatic reg_read(int a, string req);
    reg_req_i = 1; reg_we_i = 0; reg_addr_i = 4'(a);
    @(negedge clk_i);
    reg_req_i = 0;
    check(req, reg_rdata_o, exp_reg(a));
  endtask

  task automatic read_all(string req);
    for (int a = 0; a < 16; a++) reg_read(a, req);
    check({req, " R8 idle"}, reg_rdata_o, 32'h0);
  endtask

  task automatic key_sweep();
    for (int s = 0; s < 8; s++) begin
      bit ok_rd, ok_up;
      ok_rd = (s < 5) && m_rd[s];
      ok_up = (s < 5) && m_up[s];
      key_rd_slot_i = 3'(s); key_wr_slot_i = 3'(s);
      key_rd_data_i = 32'hC3A5_0F00 | 32'(s);
      key_wr_req_i = 1;
      #1;
      check(s < 5 ? "R4" : "R9", key_rd_data_o, ok_rd ? key_rd_data_i : 32'h0);
      check(s < 5 ? "R5" : "R9", {31'b0, key_wr_req_o}, {31'b0, ok_up});
      key_wr_req_i = 0;
      #1;
      check("R5 idle", {31'b0, key_wr_req_o}, 32'h0);
    end
  endtask

  task automatic outs(string req);
    check({req, " eng"}, {31'b0, engine_dis_o}, {31'b0, m_dis});
    check({req, " idx"}, {30'b0, key_idx_o}, {30'b0, m_idx});
    check({req, " sch"}, {31'b0, key_sched_dis_o}, {31'b0, m_sched});
  endtask

  function automatic logic [31:0] lock_seq(int s, int k);
    // even slots: 3,2,0,3 ; odd slots: 3,1,3,0,3
    if (s % 2 == 0) return (k == 1) ? 32'hFFFF_FFFE : (k == 2) ? 32'h0 : 32'h3;
    return (k == 1) ? 32'h1 : (k == 3) ? 32'h0 : 32'hFFFF_FFFF;
  endfunction

  initial begin
    for (int i = 0; i < 5; i++) begin m_rd[i] = 1; m_up[i] = 1; end
    m_dis = 0; m_sched = 0; m_idx = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    check("R8 reset rdata", reg_rdata_o, 32'h0);
    outs("R1");
    read_all("R1");
    key_sweep();

    for (int v = 0; v < 8; v++) begin   // key index with junk upper bits
      reg_write(1, 32'hABCD_0000 | 32'(v * 5));
      outs("R6");
      reg_read(1, "R6");
    end
    reg_write(2, 32'hFFFF_FFFF); outs("R7"); reg_read(2, "R7");
    reg_write(2, 32'hFFFF_FFFE); outs("R7"); reg_read(2, "R7");

    for (int a = 9; a < 16; a++) reg_write(a, 32'h0);  // holes
    reg_write(3, 32'h0);
    read_all("R8 hole writes");
    key_sweep();

    for (int s = 0; s < 5; s++) begin
      for (int k = 0; k < ((s % 2 == 0) ? 4 : 5); k++) begin
        reg_write(4 + s, lock_seq(s, k));
        read_all("R3");
        key_sweep();
      end
    end

    reg_write(0, 32'h0);          outs("R2"); reg_read(0, "R2");
    reg_write(0, 32'hFFFF_FFFF);  outs("R2"); reg_read(0, "R2");
    reg_write(0, 32'h0);          outs("R2"); reg_read(0, "R2");
    reg_write(0, 32'hFFFF_FFFE);  outs("R2"); reg_read(0, "R2");
    read_all("R2 final");

    rst_ni = 0;
    for (int i = 0; i < 5; i++) begin m_rd[i] = 1; m_up[i] = 1; end
    m_dis = 0; m_sched = 0; m_idx = 0;
    @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    outs("R1 reapply");
    read_all("R1 reapply");
    key_sweep();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule